// File: doc/BRIEF.md
# Transmit Rail Selector and Zero-Substitution Line Encoder

This block is the per-channel transmit front end of a DS3/E3/STS-1 line interface. It takes data on a positive input and a negative input. Both are captured on the falling edge of the transmit clock. It produces two registered flags that ask the analog driver for a positive or a negative line pulse. Two configuration inputs set how it runs: a rail-mode bit and a two-bit line-rate field. Both are held steady while traffic flows and are changed only while reset is asserted.

In dual-rail mode the two input rails are already bipolar. They go straight to the pulse flags through a fixed pipeline delay. In single-rail mode only the positive input carries NRZ data, and the encoder is always active. Marks become pulses of alternating polarity. Long runs of zeros are replaced by patterns that contain a bipolar violation, so the far end always sees enough transitions to recover the clock. The E3 rate uses four-zero (HDB3) substitution. The DS3 and STS-1 rates use three-zero (B3ZS) substitution.

Top module: `tx_rail_encoder`

## Requirements
- R1: A synchronous reset, sampled on a falling edge, clears both pulse flags. It also clears the pipeline, the violation parity (to even) and the polarity memory, so the first pulse after reset is positive.
- R2: Inputs are captured only on the falling edge of `tx_clk`, and the pulse flags change only on that edge.
- R3: With `cfg_single` = 0, a 1 on `pos_in` with `neg_in` = 0 gives `pulse_pos`, and a 1 on `neg_in` with `pos_in` = 0 gives `pulse_neg`.
- R4: With `cfg_single` = 0, both inputs high in the same sample gives no pulse.
- R5: With `cfg_single` = 1, `neg_in` has no effect on the outputs.
- R6: With `cfg_single` = 1, each data 1 is a mark, and successive marks alternate polarity.
- R7: `cfg_rate` values 2'b00 (DS3), 2'b10 (STS-1) and 2'b11 select B3ZS. Each run of three zeros becomes 00V or B0V.
- R8: `cfg_rate` = 2'b01 (E3) selects HDB3. Each run of four zeros becomes 000V or B00V.
- R9: A run is filled without B when an odd number of pulses went out since the last violation. With an even count (including zero), its first slot carries B.
- R10: A V pulse repeats the polarity of the pulse before it. A B pulse follows the normal alternation.
- R11: A bit sampled at falling edge k reaches the flags at falling edge k+N, with N = 4 for the E3 rate and N = 3 otherwise. The same N applies in both rail modes.
- R12: `pulse_pos` and `pulse_neg` are never high together.
- R13: In single-rail mode, once a pulse has gone out, no more than N-1 consecutive flag samples are empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | Transmit clock; all state moves on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_single | input | 1 | 1 = single-rail NRZ with encoding, 0 = dual-rail pass-through |
| cfg_rate | input | 2 | Line rate: 00 DS3, 01 E3, 10 STS-1, 11 treated as B3ZS |
| pos_in | input | 1 | Positive rail data, or NRZ data in single-rail mode |
| neg_in | input | 1 | Negative rail data; unused in single-rail mode |
| pulse_pos | output | 1 | Registered request for a positive line pulse |
| pulse_neg | output | 1 | Registered request for a negative line pulse |

## Verification
Every output lags its input bit by exactly N falling edges: three at the B3ZS rates and four at E3, in either rail mode. The bench drives a new bit just after each rising edge. At that same rising edge it reads the flags, which were set by the falling edge half a period earlier. Each reading is compared with the expected entry for the bit sampled N+1 falling edges before that rising edge. A reference stream for the whole case is built in the bench before the case starts. To show the flags do not move on the rising edge, the bench reads them a second time just before the next falling edge and expects the same value.

// File: rtl/tx_rail_encoder.sv
module tx_rail_encoder #(
  parameter int HDB3_RUN = 4,
  parameter int B3ZS_RUN = 3
) (
  input  logic       tx_clk,
  input  logic       rst,
  input  logic       cfg_single,
  input  logic [1:0] cfg_rate,
  input  logic       pos_in,
  input  logic       neg_in,
  output logic       pulse_pos,
  output logic       pulse_neg
);
  localparam int DEPTH = (HDB3_RUN > B3ZS_RUN) ? HDB3_RUN : B3ZS_RUN;
  localparam int TW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam logic [1:0] RATE_E3 = 2'b01;
  localparam logic [1:0] K_ZERO = 2'd0;
  localparam logic [1:0] K_MARK = 2'd1;
  localparam logic [1:0] K_BAL  = 2'd2;
  localparam logic [1:0] K_VIO  = 2'd3;

  logic [1:0]       stg_q [DEPTH];
  logic [1:0]       stg_d [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [TW-1:0]    tap;
  logic [1:0]       head;
  logic             head_vld;
  logic             last_neg_q, par_q, par_emit;
  logic             fire, fire_pos, run_full;

  assign tap      = (cfg_rate == RATE_E3) ? TW'(HDB3_RUN - 1) : TW'(B3ZS_RUN - 1);
  assign head     = stg_q[tap];
  assign head_vld = vld_q[tap];
  assign fire     = cfg_single & head_vld & (head != K_ZERO);
  assign fire_pos = (head == K_VIO) ? ~last_neg_q : last_neg_q;
  assign par_emit = (head == K_VIO) ? 1'b0 : (par_q ^ fire);
  assign vld_d    = {vld_q[DEPTH-2:0], 1'b1};

  always_comb begin
    stg_d[0] = cfg_single ? {1'b0, pos_in} : {neg_in, pos_in};
    for (int i = 1; i < DEPTH; i++) stg_d[i] = stg_q[i-1];
    run_full = cfg_single;
    for (int i = 0; i < DEPTH; i++)
      if (i <= int'(tap) && (!vld_d[i] || stg_d[i] != K_ZERO)) run_full = 1'b0;
    if (run_full) begin
      stg_d[0] = K_VIO;
      if (!par_emit) stg_d[tap] = K_BAL;
    end
  end

  always_ff @(negedge tx_clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= K_ZERO;
      vld_q      <= '0;
      last_neg_q <= 1'b1;
      par_q      <= 1'b0;
      pulse_pos  <= 1'b0;
      pulse_neg  <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= stg_d[i];
      vld_q <= vld_d;
      if (cfg_single) begin
        pulse_pos <= fire & fire_pos;
        pulse_neg <= fire & ~fire_pos;
        if (fire) last_neg_q <= ~fire_pos;
        par_q <= par_emit;
      end else begin
        pulse_pos <= head_vld & (head == K_MARK);
        pulse_neg <= head_vld & (head == K_BAL);
      end
    end
  end
endmodule

module tx_rail_encoder_chk (
  input logic       tx_clk,
  input logic       rst,
  input logic       cfg_single,
  input logic [1:0] cfg_rate,
  input logic       pos_in,
  input logic       neg_in,
  input logic       pulse_pos,
  input logic       pulse_neg
);
  logic [2:0] age;
  logic [2:0] idle;
  logic       armed;

  always_ff @(negedge tx_clk) begin
    if (rst) begin
      age   <= '0;
      idle  <= '0;
      armed <= 1'b0;
    end else begin
      if (age != 3'd7) age <= age + 3'd1;
      if (pulse_pos || pulse_neg) begin
        armed <= 1'b1;
        idle  <= '0;
      end else if (armed && idle != 3'd7) begin
        idle <= idle + 3'd1;
      end
    end
  end

  // R12
  excl_flags_chk: assert property (@(negedge tx_clk) disable iff (rst)
    !(pulse_pos && pulse_neg));

  // R1
  reset_clear_chk: assert property (@(negedge tx_clk)
    rst |=> (!pulse_pos && !pulse_neg));

  // R3
  dual_b3_lat_chk: assert property (@(negedge tx_clk) disable iff (rst)
    (age >= 3'd6 && !cfg_single && cfg_rate != 2'b01)
      |-> (pulse_pos == $past(pos_in && !neg_in, 4) && pulse_neg == $past(neg_in && !pos_in, 4)));

  // R3
  dual_e3_lat_chk: assert property (@(negedge tx_clk) disable iff (rst)
    (age >= 3'd7 && !cfg_single && cfg_rate == 2'b01)
      |-> (pulse_pos == $past(pos_in && !neg_in, 5) && pulse_neg == $past(neg_in && !pos_in, 5)));

  // R13
  zero_run_chk: assert property (@(negedge tx_clk) disable iff (rst)
    (armed && cfg_single) |-> (idle < ((cfg_rate == 2'b01) ? 3'd4 : 3'd3)));
endmodule

bind tx_rail_encoder tx_rail_encoder_chk u_chk (
  .tx_clk(tx_clk), .rst(rst), .cfg_single(cfg_single), .cfg_rate(cfg_rate),
  .pos_in(pos_in), .neg_in(neg_in), .pulse_pos(pulse_pos), .pulse_neg(pulse_neg)
);

// File: tb/tx_rail_encoder_tb.sv
module tx_rail_encoder_tb;
  localparam int CLK_P = 10;

  logic       tx_clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_single = 1'b0;
  logic [1:0] cfg_rate = 2'b00;
  logic       pos_in = 1'b0;
  logic       neg_in = 1'b0;
  logic       pulse_pos, pulse_neg;

  int  total = 0;
  int  bad = 0;
  bit  done = 0;
  bit  ep [64];
  bit  en [64];

  always #(CLK_P/2) tx_clk = ~tx_clk;

  tx_rail_encoder u_dut (
    .tx_clk(tx_clk), .rst(rst), .cfg_single(cfg_single), .cfg_rate(cfg_rate),
    .pos_in(pos_in), .neg_in(neg_in), .pulse_pos(pulse_pos), .pulse_neg(pulse_neg)
  );

  task automatic check(input string tag, input bit gp, input bit gn, input bit xp, input bit xn);
    total++;
    if (gp !== xp || gn !== xn) begin
      bad++;
      $display("FAIL %s: pos/neg got %b%b expected %b%b at %0t", tag, gp, gn, xp, xn, $time);
    end
  endtask

  task automatic run_case(input string tag, input bit single, input logic [1:0] rate,
                          input logic [63:0] pv, input logic [63:0] nv, input int len);
    logic [1:0] code [64];
    int  win;
    int  run;
    int  idle;
    bit  par, lneg, armed, sp, sn;
    win = (rate == 2'b01) ? 4 : 3;
    for (int i = 0; i < 64; i++) begin ep[i] = 0; en[i] = 0; code[i] = 2'd0; end
    if (single) begin
      run = 0; par = 0;
      for (int i = 0; i < len; i++) begin
        if (pv[i]) begin
          code[i] = 2'd1; par = ~par; run = 0;
        end else begin
          run++;
          if (run == win) begin
            code[i] = 2'd3;
            if (!par) code[i-win+1] = 2'd2;
            par = 0; run = 0;
          end
        end
      end
      lneg = 1;
      for (int i = 0; i < len; i++) begin
        if (code[i] == 2'd1 || code[i] == 2'd2) begin
          ep[i] = lneg; en[i] = ~lneg; lneg = ~lneg;
        end else if (code[i] == 2'd3) begin
          ep[i] = ~lneg; en[i] = lneg;
        end
      end
    end else begin
      for (int i = 0; i < len; i++) begin
        ep[i] = pv[i] & ~nv[i];
        en[i] = nv[i] & ~pv[i];
      end
    end

    @(posedge tx_clk);
    cfg_single = single; cfg_rate = rate; rst = 1'b1; pos_in = 1'b0; neg_in = 1'b0;
    repeat (2) @(negedge tx_clk);
    @(posedge tx_clk);
    rst = 1'b0;
    idle = 0; armed = 0;
    for (int t = 0; t <= len + win; t++) begin
      if (t > 0) @(posedge tx_clk);
      sp = pulse_pos; sn = pulse_neg;
      if (t == 0) check({tag, " R1 reset state"}, sp, sn, 1'b0, 1'b0);
      else if (t - 1 - win >= 0) check({tag, " stream"}, sp, sn, ep[t-1-win], en[t-1-win]);
      check({tag, " R12 exclusive"}, sp & sn, 1'b0, 1'b0, 1'b0);
      if (single) begin
        if (sp | sn) begin armed = 1; idle = 0; end
        else if (armed) idle++;
        check({tag, " R13 zero run"}, idle >= win, 1'b0, 1'b0, 1'b0);
      end
      pos_in = (t < len) ? pv[t] : 1'b0;
      neg_in = (t < len) ? nv[t] : 1'b0;
      #(CLK_P/2 - 1);
      check({tag, " R2 no change off falling edge"}, pulse_pos, pulse_neg, sp, sn);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, got hung expected done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R3 R4 R11: dual rail, DS3 rate, includes both-high samples
    run_case("R3 R4 R11 dual DS3", 1'b0, 2'b00, 64'h0000_00F0_A5C3, 64'h0000_0F30_3C96, 40);
    // R3 R11: dual rail, E3 rate, four-edge delay
    run_case("R3 R11 dual E3", 1'b0, 2'b01, 64'h0000_0033_9A61, 64'h0000_0044_2116, 36);
    // R6 R7 R9 R10: single rail B3ZS, negative rail held high
    run_case("R6 R7 R9 R10 B3ZS mix", 1'b1, 2'b00, 64'h0000_8C40_2310_0461, 64'hFFFF_FFFF_FFFF_FFFF, 44);
    // R5: same data, different negative rail, same expectation
    run_case("R5 neg ignored", 1'b1, 2'b00, 64'h0000_8C40_2310_0461, 64'h5A5A_C3C3_0F0F_9669, 44);
    // R7 R9: STS-1 all zeros, alternating B0V
    run_case("R7 R9 STS1 zeros", 1'b1, 2'b10, 64'h0, 64'h0, 24);
    // R8 R9 R10 R11: E3 HDB3 mixed
    run_case("R8 R9 R10 R11 HDB3 mix", 1'b1, 2'b01, 64'h0001_8420_0C01_0009, 64'h0, 48);
    // R8: E3 all zeros
    run_case("R8 HDB3 zeros", 1'b1, 2'b01, 64'h0, 64'hFFFF_0000_FFFF_0000, 24);
    // R7: rate code 11 behaves as B3ZS
    run_case("R7 rate 11", 1'b1, 2'b11, 64'h0000_0000_9001_0301, 64'h0, 32);
    // R1: re-run after reset gives the identical stream
    run_case("R1 R6 restart", 1'b1, 2'b00, 64'h0000_8C40_2310_0461, 64'h0, 44);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule